// File: doc/BRIEF.md
# Refresh Command Timing Scheduler

This block sits on the controller side of a multi-bank DRAM interface. It takes refresh requests, holds each one until every timing rule that applies to the targeted banks is met, and then drives a single refresh command onto the memory command bus. A request names one bank in single-bank mode, or a set of banks in multibank mode. The requester keeps its request valid until it sees the acknowledge pulse.

The scheduler also watches notifications of the read, write and refresh commands that other parts of the controller place on the bus, with their bank numbers. These notifications feed the same timers that govern its own refreshes. Each rule is enforced by its own timer or history:
- a row-cycle time for each bank,
- a sliding window that limits the number of bank activations,
- an extra spacing for refreshes that name three or four banks,
- two idle cycles around every multibank refresh.

All timing values are parameters counted in clock cycles. While no refresh is issued, the bus is held at deselect.

Top module: `ref_sched`

## Requirements
- R1: After reset, and in every cycle that carries no refresh, `cs_n_o` and `ref_n_o` are high, `ba_o` and `addr_o` are zero and `ack_o` is low.
- R2: In single-bank mode (`mode_i`=0) a refresh drives `cs_n_o`=0 and `ref_n_o`=0, with the bank index from `req_bank_i` on `ba_o` and zero on `addr_o`. `ack_o` is high in that same cycle.
- R3: In multibank mode (`mode_i`=1) a refresh drives the request mask on `addr_o`, where bit i selects bank i, and zero on `ba_o`.
- R4: A refresh of a bank is issued at least T_RC cycles after the last command to that bank. This covers both the scheduler's own refreshes and reported commands. In multibank mode it applies to every bank in the mask.
- R5: A multibank request whose mask names no bank, or more than MB_MAX banks, is never issued, and `ready_o` stays low while it is presented.
- R6: In any T_SAW consecutive cycles, the number of bank activations is at most SAW_MAX. Each reported command counts one activation, and each refresh counts one for each bank it names.
- R7: A multibank refresh that names three or more banks is issued at least T_MMD cycles after the previous multibank refresh.
- R8: A multibank refresh has at least MB_IDLE (2) clear cycles after the previous bank command of any kind. The scheduler's next refresh has at least MB_IDLE clear cycles after a multibank refresh.
- R9: `ready_o` is high only when a valid request meets every rule. The refresh and `ack_o` then appear in the next cycle. Two refreshes are never issued in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0 = single-bank refresh, 1 = multibank refresh |
| req_valid_i | input | 1 | Refresh request pending, held until `ack_o` |
| req_bank_i | input | BA_W | Bank index used in single-bank mode |
| req_mask_i | input | NUM_BANKS | Bank mask used in multibank mode |
| ready_o | output | 1 | The request meets every rule and issues at the next edge |
| ack_o | output | 1 | High in the cycle the refresh is on the bus |
| ext_valid_i | input | 1 | Another bank command is on the bus in this cycle |
| ext_bank_i | input | BA_W | Bank of that command |
| cs_n_o | output | 1 | Chip select, active low |
| ref_n_o | output | 1 | Refresh strobe, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | NUM_BANKS | Address bus, carrying the bank mask in multibank mode |

## Verification
The checker relies on three assumptions about the other commands on the shared bus:
- No reported command falls in a cycle in which the scheduler drives a refresh.
- No reported command targets a bank that is still inside its row-cycle time.
- No reported command follows a multibank refresh within two cycles.

The stimulus keeps within these assumptions. It raises a notification only while the scheduler is idle, and it separates scenarios with long idle stretches, so that every timer has expired before the next pattern starts. The mode input only changes while the acknowledge is high or no request is pending.

// File: rtl/ref_sched_pkg.sv
package ref_sched_pkg;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_MULTI  = 1'b1
  } ref_mode_e;

endpackage

// File: rtl/ref_down_timer.sv
module ref_down_timer #(
  parameter int LOAD_A = 1,
  parameter int LOAD_B = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ld_a,
  input  logic ld_b,
  output logic busy
);
  localparam int MAXV = (LOAD_A > LOAD_B) ? LOAD_A : LOAD_B;
  localparam int CW   = $clog2(MAXV + 2);

  logic [CW-1:0] cnt;
  logic [CW-1:0] nxt_load;

  always_comb begin
    if (ld_a && ld_b) nxt_load = CW'(MAXV);
    else if (ld_a)    nxt_load = CW'(LOAD_A);
    else              nxt_load = CW'(LOAD_B);
  end

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (ld_a || ld_b)  cnt <= nxt_load;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/ref_saw_window.sv
module ref_saw_window #(
  parameter int DEPTH = 8,
  parameter int CW    = 3,
  parameter int SW    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cur_act,
  output logic [SW-1:0] win_sum
);
  logic [CW-1:0] hist [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) hist[0] <= '0;
    else     hist[0] <= cur_act;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) hist[i] <= '0;
      else     hist[i] <= hist[i-1];
    end
  end

  always_comb begin
    win_sum = SW'(cur_act);
    for (int i = 0; i < DEPTH; i++) win_sum = win_sum + SW'(hist[i]);
  end
endmodule

// File: rtl/ref_sched.sv
module ref_sched
  import ref_sched_pkg::*;
#(
  parameter int NUM_BANKS = 16,
  parameter int T_RC      = 8,
  parameter int T_SAW     = 10,
  parameter int SAW_MAX   = 4,
  parameter int T_MMD     = 6,
  parameter int MB_MAX    = 4,
  parameter int MB_IDLE   = 2,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode_i,
  input  logic                 req_valid_i,
  input  logic [BA_W-1:0]      req_bank_i,
  input  logic [NUM_BANKS-1:0] req_mask_i,
  output logic                 ready_o,
  output logic                 ack_o,
  input  logic                 ext_valid_i,
  input  logic [BA_W-1:0]      ext_bank_i,
  output logic                 cs_n_o,
  output logic                 ref_n_o,
  output logic [BA_W-1:0]      ba_o,
  output logic [NUM_BANKS-1:0] addr_o
);
  localparam int NB_CW  = $clog2(NUM_BANKS + 1);
  localparam int ACT_W  = $clog2(MB_MAX + 2);
  localparam int SUM_W  = $clog2((MB_MAX + 1) * T_SAW + 1) + 1;
  localparam int HDEPTH = T_SAW - 2;

  ref_mode_e            mode;
  logic [NUM_BANKS-1:0] req_banks;
  logic [NUM_BANKS-1:0] ext_hit;
  logic [NUM_BANKS-1:0] rc_busy;
  logic [NB_CW-1:0]     req_n;
  logic [ACT_W-1:0]     own_cnt_q;
  logic [ACT_W-1:0]     cur_act;
  logic [SUM_W-1:0]     win_sum;
  logic                 gap_busy, mbq_busy, mmd_busy;
  logic                 mask_ok, trc_ok, saw_ok, gap_ok, mmd_ok;
  logic                 issue, issue_mb;

  assign mode = ref_mode_e'(mode_i);

  // Banks named by the pending request and their count
  always_comb begin
    req_n = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      req_banks[b] = (mode == MODE_MULTI) ? req_mask_i[b]
                                          : (req_bank_i == BA_W'(b));
      ext_hit[b]   = ext_valid_i && (ext_bank_i == BA_W'(b));
      req_n        = req_n + NB_CW'(req_banks[b]);
    end
  end

  // Row-cycle timers, one for each bank
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ref_down_timer #(.LOAD_A(T_RC - 2), .LOAD_B(T_RC - 1)) u_rc (
      .clk  (clk),
      .rst  (rst),
      .ld_a (ext_hit[b]),
      .ld_b (issue && req_banks[b]),
      .busy (rc_busy[b])
    );
  end

  // Clear cycles before a multibank refresh
  ref_down_timer #(.LOAD_A(MB_IDLE - 1), .LOAD_B(MB_IDLE)) u_gap (
    .clk  (clk),
    .rst  (rst),
    .ld_a (ext_valid_i),
    .ld_b (issue),
    .busy (gap_busy)
  );

  // Clear cycles after a multibank refresh
  ref_down_timer #(.LOAD_A(0), .LOAD_B(MB_IDLE)) u_mbq (
    .clk  (clk),
    .rst  (rst),
    .ld_a (1'b0),
    .ld_b (issue_mb),
    .busy (mbq_busy)
  );

  // Spacing for refreshes that name three or more banks
  ref_down_timer #(.LOAD_A(0), .LOAD_B(T_MMD - 1)) u_mmd (
    .clk  (clk),
    .rst  (rst),
    .ld_a (1'b0),
    .ld_b (issue_mb),
    .busy (mmd_busy)
  );

  // Activation window
  assign cur_act = own_cnt_q + ACT_W'(ext_valid_i);

  ref_saw_window #(.DEPTH(HDEPTH), .CW(ACT_W), .SW(SUM_W)) u_saw (
    .clk     (clk),
    .rst     (rst),
    .cur_act (cur_act),
    .win_sum (win_sum)
  );

  // Rule evaluation
  always_comb begin
    mask_ok = (mode == MODE_SINGLE) ||
              ((int'(req_n) >= 1) && (int'(req_n) <= MB_MAX));
    trc_ok  = ~|(req_banks & (rc_busy | ext_hit));
    saw_ok  = (int'(win_sum) + int'(req_n)) <= SAW_MAX;
    if (mode == MODE_MULTI) gap_ok = !gap_busy && !ext_valid_i;
    else                    gap_ok = !mbq_busy;
    mmd_ok  = !((mode == MODE_MULTI) && (int'(req_n) >= 3) && mmd_busy);
  end

  assign issue    = req_valid_i && !ack_o && mask_ok && trc_ok &&
                    saw_ok && gap_ok && mmd_ok;
  assign issue_mb = issue && (mode == MODE_MULTI);
  assign ready_o  = issue;

  // Registered command bus
  always_ff @(posedge clk) begin
    if (rst || !issue) begin
      cs_n_o    <= 1'b1;
      ref_n_o   <= 1'b1;
      ba_o      <= '0;
      addr_o    <= '0;
      ack_o     <= 1'b0;
      own_cnt_q <= '0;
    end else begin
      cs_n_o    <= 1'b0;
      ref_n_o   <= 1'b0;
      ba_o      <= (mode == MODE_SINGLE) ? req_bank_i : '0;
      addr_o    <= (mode == MODE_MULTI) ? req_mask_i : '0;
      ack_o     <= 1'b1;
      own_cnt_q <= ACT_W'(req_n);
    end
  end
endmodule

// File: rtl/ref_sched_chk.sv
module ref_sched_chk #(
  parameter int NUM_BANKS = 16,
  parameter int T_RC      = 8,
  parameter int T_SAW     = 10,
  parameter int SAW_MAX   = 4,
  parameter int T_MMD     = 6,
  parameter int MB_MAX    = 4,
  parameter int MB_IDLE   = 2,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ready_o,
  input logic                 ack_o,
  input logic                 ext_valid_i,
  input logic [BA_W-1:0]      ext_bank_i,
  input logic                 cs_n_o,
  input logic                 ref_n_o,
  input logic [BA_W-1:0]      ba_o,
  input logic [NUM_BANKS-1:0] addr_o
);
  localparam int CAP  = ((T_RC > T_MMD) ? T_RC : T_MMD) + MB_IDLE + 1;
  localparam int HLEN = T_SAW - 1;

  logic own_cmd, is_mb;
  logic [NUM_BANKS-1:0] own_hit, rep_hit;
  int   age_bank [NUM_BANKS];
  int   age_cmd, age_mb, acts_now, win_total;
  int   hist [HLEN];

  assign own_cmd = !ref_n_o;
  assign is_mb   = own_cmd && (addr_o != '0);

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      own_hit[b] = own_cmd && (is_mb ? addr_o[b] : (ba_o == BA_W'(b)));
      rep_hit[b] = ext_valid_i && (ext_bank_i == BA_W'(b));
    end
    acts_now = (own_cmd ? (is_mb ? $countones(addr_o) : 1) : 0) +
               (ext_valid_i ? 1 : 0);
    win_total = acts_now;
    for (int i = 0; i < HLEN; i++) win_total = win_total + hist[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < HLEN; i++) hist[i] <= 0;
      age_cmd <= CAP;
      age_mb  <= CAP;
    end else begin
      hist[0] <= acts_now;
      for (int i = 1; i < HLEN; i++) hist[i] <= hist[i-1];
      age_cmd <= (own_cmd || ext_valid_i) ? 0 : ((age_cmd < CAP) ? age_cmd + 1 : CAP);
      age_mb  <= is_mb ? 0 : ((age_mb < CAP) ? age_mb + 1 : CAP);
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_age
    always_ff @(posedge clk) begin
      if (rst)                         age_bank[b] <= CAP;
      else if (own_hit[b] || rep_hit[b]) age_bank[b] <= 0;
      else if (age_bank[b] < CAP)      age_bank[b] <= age_bank[b] + 1;
    end

    p_row_cycle_r4: assert property (@(posedge clk) disable iff (rst)
      own_hit[b] |-> age_bank[b] >= T_RC - 1);
  end

  p_idle_bus_r1: assert property (@(posedge clk) disable iff (rst)
    ref_n_o |-> (cs_n_o && ba_o == '0 && addr_o == '0 && !ack_o));

  p_cmd_ack_r2: assert property (@(posedge clk) disable iff (rst)
    own_cmd |-> (ack_o && !cs_n_o));

  p_mb_fields_r3: assert property (@(posedge clk) disable iff (rst)
    is_mb |-> (ba_o == '0 && $countones(addr_o) <= MB_MAX));

  p_window_r6: assert property (@(posedge clk) disable iff (rst)
    win_total <= SAW_MAX);

  p_mmd_space_r7: assert property (@(posedge clk) disable iff (rst)
    (is_mb && $countones(addr_o) >= 3) |-> age_mb >= T_MMD - 1);

  p_gap_before_r8: assert property (@(posedge clk) disable iff (rst)
    is_mb |-> age_cmd >= MB_IDLE);

  p_gap_after_r8: assert property (@(posedge clk) disable iff (rst)
    own_cmd |-> age_mb >= MB_IDLE);

  p_ready_issue_r9: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> (own_cmd && ack_o));

  p_no_back_to_back_r9: assert property (@(posedge clk) disable iff (rst)
    own_cmd |=> !own_cmd);

  p_in_no_collide: assert property (@(posedge clk) disable iff (rst)
    !(ext_valid_i && own_cmd));
endmodule

bind ref_sched ref_sched_chk #(
  .NUM_BANKS (NUM_BANKS),
  .T_RC      (T_RC),
  .T_SAW     (T_SAW),
  .SAW_MAX   (SAW_MAX),
  .T_MMD     (T_MMD),
  .MB_MAX    (MB_MAX),
  .MB_IDLE   (MB_IDLE)
) u_chk (.*);

// File: tb/ref_sched_bench.sv
module ref_sched_bench;
  localparam int NB   = 16;
  localparam int BW   = 4;
  localparam int TRC  = 8;
  localparam int TSAW = 10;
  localparam int TMMD = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode = 1'b0;
  logic          req_valid = 1'b0;
  logic [BW-1:0] req_bank = '0;
  logic [NB-1:0] req_mask = '0;
  logic          ready, ack;
  logic          ext_valid = 1'b0;
  logic [BW-1:0] ext_bank = '0;
  logic          cs_n, ref_n;
  logic [BW-1:0] ba;
  logic [NB-1:0] addr;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ref_sched #(.NUM_BANKS(NB), .T_RC(TRC), .T_SAW(TSAW), .SAW_MAX(4),
              .T_MMD(TMMD), .MB_MAX(4), .MB_IDLE(2)) u_ref_sched (
    .clk(clk), .rst(rst), .mode_i(mode), .req_valid_i(req_valid),
    .req_bank_i(req_bank), .req_mask_i(req_mask), .ready_o(ready),
    .ack_o(ack), .ext_valid_i(ext_valid), .ext_bank_i(ext_bank),
    .cs_n_o(cs_n), .ref_n_o(ref_n), .ba_o(ba), .addr_o(addr));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ack(output int c);
    c = -1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (ack) begin
        c = cyc;
        req_valid = 1'b0;
        break;
      end
    end
  endtask

  task automatic req_single(input int b);
    mode = 1'b0; req_bank = BW'(b); req_mask = '0; req_valid = 1'b1;
  endtask

  task automatic req_multi(input logic [NB-1:0] m);
    mode = 1'b1; req_mask = m; req_bank = '0; req_valid = 1'b1;
  endtask

  task automatic t_reset;
    chk(cs_n && ref_n, "R1 reset strobes", {cs_n, ref_n}, 3);
    chk(!ack && !ready, "R1 reset ack/ready", {ack, ready}, 0);
    chk(ba == 0 && addr == 0, "R1 reset bus", int'(addr), 0);
  endtask

  task automatic t_single_basic;
    int r, c;
    idle(20);
    req_single(11); r = cyc;
    #1 chk(ready == 1'b1, "R9 ready when legal", ready, 1);
    wait_ack(c);
    chk(c - r == 1, "R9 issue latency", c - r, 1);
    chk(!cs_n && !ref_n, "R2 strobes low", {cs_n, ref_n}, 0);
    chk(ba == 4'd11, "R2 bank on ba", ba, 11);
    chk(addr == 0, "R2 addr zero", int'(addr), 0);
    @(negedge clk);
    chk(cs_n && ref_n && !ack && ba == 0, "R1 idle after cmd", {cs_n, ref_n, ack}, 6);
  endtask

  task automatic t_trc_own;
    int c1, c2;
    idle(20);
    req_single(5);
    wait_ack(c1);
    req_single(5);
    @(negedge clk);
    #1 chk(ready == 1'b0, "R9 ready low while blocked", ready, 0);
    wait_ack(c2);
    chk(c2 - c1 == TRC, "R4 own row cycle", c2 - c1, TRC);
  endtask

  task automatic t_trc_ext;
    int p, c;
    idle(20);
    ext_valid = 1'b1; ext_bank = 4'd7; p = cyc;
    req_single(7);
    @(negedge clk);
    ext_valid = 1'b0;
    wait_ack(c);
    chk(c - p == TRC, "R4 reported command row cycle", c - p, TRC);
    chk(ba == 4'd7, "R2 bank seven", ba, 7);
  endtask

  task automatic t_trc_mb;
    int c1, c2;
    idle(20);
    req_single(0);
    wait_ack(c1);
    req_multi(16'h0001);
    wait_ack(c2);
    chk(c2 - c1 == TRC, "R4 multibank row cycle", c2 - c1, TRC);
  endtask

  task automatic t_mb_saw;
    int r, c1, c2;
    idle(20);
    req_multi(16'h000F); r = cyc;
    wait_ack(c1);
    chk(c1 - r == 1, "R3 multibank latency", c1 - r, 1);
    chk(addr == 16'h000F && ba == 0, "R3 mask on addr", int'(addr), 15);
    req_multi(16'h0010);
    wait_ack(c2);
    chk(c2 - c1 == TSAW, "R6 activation window", c2 - c1, TSAW);
    chk(addr == 16'h0010, "R3 second mask", int'(addr), 16);
  endtask

  task automatic t_mmd;
    int c1, c2;
    idle(20);
    req_multi(16'h0020);
    wait_ack(c1);
    req_multi(16'h01C0);
    wait_ack(c2);
    chk(c2 - c1 == TMMD, "R7 three-bank spacing", c2 - c1, TMMD);
    idle(20);
    req_multi(16'h0200);
    wait_ack(c1);
    req_multi(16'h0C00);
    wait_ack(c2);
    chk(c2 - c1 == 3, "R8 two-bank follows after idle pair", c2 - c1, 3);
  endtask

  task automatic t_gap_ext;
    int p, c;
    idle(20);
    ext_valid = 1'b1; ext_bank = 4'd9; p = cyc;
    req_multi(16'h0003);
    @(negedge clk);
    ext_valid = 1'b0;
    wait_ack(c);
    chk(c - p == 3, "R8 idle before multibank", c - p, 3);
  endtask

  task automatic t_gap_after;
    int c1, c2;
    idle(20);
    req_multi(16'h0100);
    wait_ack(c1);
    req_single(2);
    wait_ack(c2);
    chk(c2 - c1 == 3, "R8 idle after multibank", c2 - c1, 3);
  endtask

  task automatic t_bad_mask;
    bit ok;
    idle(20);
    ok = 1'b1;
    req_multi(16'h001F);
    for (int i = 0; i < 20; i++) begin
      #1 if (ready || !ref_n) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, "R5 five-bank mask refused", ok, 1);
    ok = 1'b1;
    req_multi(16'h0000);
    for (int i = 0; i < 20; i++) begin
      #1 if (ready || !ref_n) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, "R5 empty mask refused", ok, 1);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single_basic();
    t_trc_own();
    t_trc_ext();
    t_trc_mb();
    t_mb_saw();
    t_mmd();
    t_gap_ext();
    t_gap_after();
    t_bad_mask();
    idle(5);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule